// File: doc/BRIEF.md
# PCI Target Configuration Responder

This block is the front end of a target-only PCI device. It watches the multiplexed address/data bus. It claims Type 0 configuration cycles aimed at it and memory cycles that fall inside its single memory window. It then completes the data phases with the target handshake. It owns the configuration header: identification, command, status, class/revision, header type and one 32-bit memory base register. Optional registers that a target-only device does not need are hardwired to zero. Parity, mastering, self-test, expansion ROM and card-bridge registers are not part of it.

Address decode takes two clocks. The block registers the decode result in the clock after the address phase and asserts DEVSEL# in the clock after that, which is medium decode timing. TRDY# goes low together with DEVSEL#, so no extra decode-complete state is needed. Linear memory bursts stream one dword per clock. When the two low address bits of a memory command ask for any other burst order, the block transfers only the first data phase and signals disconnect with data on it.

The memory side is a plain, wait-state-free port. Every completed write data phase shows up as a one-clock `mem_wvalid` beat with its dword offset, data and byte enables. The back end has no ready signal and must take every beat. Read data is taken combinationally from `mem_rdata` for the offset on `mem_addr`. Bus signals are split into input, output and output-enable pins. The pad ring merges them.

Top module: `pci_cfg_target`

## Requirements
- R1: A configuration cycle is claimed only when IDSEL is high in the address phase, the command on C/BE# is 1010 (read) or 1011 (write) and AD[1:0]=00. AD[7:2] selects the dword, and dwords with no register read as zero.
- R2: DEVSEL# stays high in the clock after the address phase and first goes low in the second clock after it, with TRDY# low in that same clock.
- R3: Dword 0 reads {DEVICE_ID, VENDOR_ID} and dword 2 reads {CLASS_CODE, REVISION}.
- R4: In dword 3, bits 23:16 read {MULTI_FUNC, 7'b0000000}, so a single-function target reads 00h. The cache-line size, latency and self-test bytes read zero and ignore writes. Dword 15, which holds the grant/latency bytes and the interrupt bytes, reads zero.
- R5: Dword 1 bit 1 is the writable memory-space enable and the other command bits read zero. The status half reads 0200h, which places 01 (medium) in bits 10:9 of the dword's upper half.
- R6: Dword 4 is the memory base register. Bits 31:BAR_LOG2 are writable and the lower bits read zero. Writing all ones reads back the size mask (FFFFF000h for a 4 KiB window).
- R7: Configuration writes change only the byte lanes whose C/BE# bit is low in the data phase.
- R8: A memory read (0110) or write (0111) is claimed only when the memory-space enable is set and AD[31:BAR_LOG2] equals the base. `hit` is high for exactly the clock after such an address phase.
- R9: With AD[1:0]=00 on a memory command, every clock in which IRDY# and TRDY# are both low transfers one dword and advances the offset by one. STOP# stays high. The transaction ends after the data phase that completes with FRAME# high.
- R10: With AD[1:0] other than 00 on a memory command, STOP# goes low with TRDY# in the first data phase. After that transfer TRDY# goes high while STOP# and DEVSEL# stay low until FRAME# is high, so exactly one dword moves.
- R11: A completed memory write phase raises `mem_wvalid` for that clock with `mem_addr`, `mem_wdata` = AD and `mem_be` = inverted C/BE#. In read data phases `ad_out` carries the selected data and `ad_oe` is high.
- R12: The clock after a transaction ends, DEVSEL#, TRDY# and STOP# are driven high with `ctl_oe` high. In the clock after that, `ctl_oe` is low.
- R13: Out of reset DEVSEL#, TRDY# and STOP# are high, `ctl_oe` and `ad_oe` are low, and the command bits and base register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | FRAME# from the initiator |
| irdy_n | input | 1 | IRDY# from the initiator |
| idsel | input | 1 | Configuration chip select |
| cbe_n | input | 4 | Command in the address phase, byte enables in data phases |
| ad_in | input | 32 | Address/data bus as received |
| ad_out | output | 32 | Read data driven onto the bus |
| ad_oe | output | 1 | Enable for `ad_out` |
| devsel_n | output | 1 | DEVSEL# |
| trdy_n | output | 1 | TRDY# |
| stop_n | output | 1 | STOP# |
| ctl_oe | output | 1 | Enable for DEVSEL#, TRDY# and STOP# |
| hit | output | 1 | One-clock memory-window match |
| mem_addr | output | BAR_LOG2-2 | Dword offset inside the memory window |
| mem_wvalid | output | 1 | Memory write beat, no back-pressure |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables, active high |
| mem_rdata | input | 32 | Memory read data for `mem_addr` |

## Verification
Counting from the clock that carries the address phase, `hit` is due one clock later. DEVSEL#, TRDY#, STOP#, `ad_oe` and read data are due two clocks later. A write beat lands in the clock whose closing edge completes it, and the release drive comes in the clock after the last transfer. The bench changes inputs just after each rising edge and samples every output at the following falling edge. A transaction task reads each result in exactly the clock where it is due, so an early or late DEVSEL# shows up as a wrong value in a named clock and not as a timing race. The write monitor also samples at falling edges, so each beat is logged against the clock that completes it.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  localparam int unsigned IDX_W = 6;

  localparam logic [IDX_W-1:0] IDX_IDENT = 6'd0;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 6'd1;
  localparam logic [IDX_W-1:0] IDX_CLASS = 6'd2;
  localparam logic [IDX_W-1:0] IDX_HDR   = 6'd3;
  localparam logic [IDX_W-1:0] IDX_BASE  = 6'd4;

  // Status half of dword 1: only the select-timing field is non-zero (medium).
  localparam logic [15:0] STATUS_RO = 16'h0200;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC,
    ST_DATA,
    ST_DISC,
    ST_TURN
  } bus_state_e;

endpackage

// File: rtl/pci_cfg_regs.sv
module pci_cfg_regs
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hABCD,
  parameter logic [15:0] DEVICE_ID  = 16'h0F31,
  parameter logic [7:0]  REVISION   = 8'h02,
  parameter logic [23:0] CLASS_CODE = 24'h058000,
  parameter bit          MULTI_FUNC = 1'b0,
  parameter int unsigned BAR_LOG2   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [31:0]        wdata,
  input  logic [3:0]         be,
  output logic [31:0]        rdata,
  output logic               mem_en,
  output logic [31:BAR_LOG2] bar_base
);

  localparam logic [7:0] HDR_TYPE = {MULTI_FUNC, 7'b0000000};

  logic               mem_en_q;
  logic [31:BAR_LOG2] bar_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_en_q <= 1'b0;
      bar_q    <= '0;
    end else if (we) begin
      if (idx == IDX_CTRL && be[0]) begin
        mem_en_q <= wdata[1];
      end
      if (idx == IDX_BASE) begin
        for (int b = BAR_LOG2; b < 32; b++) begin
          if (be[b/8]) begin
            bar_q[b] <= wdata[b];
          end
        end
      end
    end
  end

  always_comb begin
    unique case (idx)
      IDX_IDENT: rdata = {DEVICE_ID, VENDOR_ID};
      IDX_CTRL:  rdata = {STATUS_RO, 14'b0, mem_en_q, 1'b0};
      IDX_CLASS: rdata = {CLASS_CODE, REVISION};
      IDX_HDR:   rdata = {8'h00, HDR_TYPE, 8'h00, 8'h00};
      IDX_BASE:  rdata = {bar_q, {BAR_LOG2{1'b0}}};
      default:   rdata = 32'h0000_0000;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[BAR_LOG2-1:2], wdata[0]};

  assign mem_en   = mem_en_q;
  assign bar_base = bar_q;

endmodule

// File: rtl/pci_cfg_decode.sv
module pci_cfg_decode
  import pci_cfg_pkg::*;
#(
  parameter int unsigned BAR_LOG2 = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic [31:BAR_LOG2] ad_hi,
  input  logic [1:0]         ad_lo,
  input  logic [3:0]         cmd,
  input  logic               idsel,
  input  logic               mem_en,
  input  logic [31:BAR_LOG2] bar_base,
  output logic               cfg_sel_q,
  output logic               mem_sel_q,
  output logic               rd_q,
  output logic               disc_q
);

  logic is_cfg_cmd;
  logic is_mem_cmd;

  assign is_cfg_cmd = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
  assign is_mem_cmd = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);

  // First decode clock: compare and register; claim happens one clock later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sel_q <= 1'b0;
      mem_sel_q <= 1'b0;
      rd_q      <= 1'b0;
      disc_q    <= 1'b0;
    end else begin
      cfg_sel_q <= strobe && idsel && is_cfg_cmd && (ad_lo == 2'b00);
      mem_sel_q <= strobe && mem_en && is_mem_cmd && (ad_hi == bar_base);
      rd_q      <= ~cmd[0];
      disc_q    <= is_mem_cmd && (ad_lo != 2'b00);
    end
  end

endmodule

// File: rtl/pci_cfg_target.sv
module pci_cfg_target
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hABCD,
  parameter logic [15:0] DEVICE_ID  = 16'h0F31,
  parameter logic [7:0]  REVISION   = 8'h02,
  parameter logic [23:0] CLASS_CODE = 24'h058000,
  parameter bit          MULTI_FUNC = 1'b0,
  parameter int unsigned BAR_LOG2   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic                idsel,
  input  logic [3:0]          cbe_n,
  input  logic [31:0]         ad_in,
  output logic [31:0]         ad_out,
  output logic                ad_oe,
  output logic                devsel_n,
  output logic                trdy_n,
  output logic                stop_n,
  output logic                ctl_oe,
  output logic                hit,
  output logic [BAR_LOG2-3:0] mem_addr,
  output logic                mem_wvalid,
  output logic [31:0]         mem_wdata,
  output logic [3:0]          mem_be,
  input  logic [31:0]         mem_rdata
);

  localparam int unsigned KEEP = (BAR_LOG2 > 8) ? BAR_LOG2 : 8;

  bus_state_e         state_q;
  logic               frame_q;
  logic [KEEP-1:2]    addr_q;
  logic               cfg_q;
  logic               rd_q;
  logic               disc_q;

  logic               addr_strobe;
  logic               xfer;
  logic               cfg_we;
  logic [31:0]        cfg_rdata;
  logic               mem_en;
  logic [31:BAR_LOG2] bar_base;
  logic               dec_cfg;
  logic               dec_mem;
  logic               dec_rd;
  logic               dec_disc;

  assign addr_strobe = (state_q == ST_IDLE) && !frame_n && frame_q;
  assign xfer        = (state_q == ST_DATA) && !irdy_n;
  assign cfg_we      = xfer && cfg_q && !rd_q;

  pci_cfg_regs #(
    .VENDOR_ID  (VENDOR_ID),
    .DEVICE_ID  (DEVICE_ID),
    .REVISION   (REVISION),
    .CLASS_CODE (CLASS_CODE),
    .MULTI_FUNC (MULTI_FUNC),
    .BAR_LOG2   (BAR_LOG2)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .idx      (addr_q[7:2]),
    .wdata    (ad_in),
    .be       (~cbe_n),
    .rdata    (cfg_rdata),
    .mem_en   (mem_en),
    .bar_base (bar_base)
  );

  pci_cfg_decode #(
    .BAR_LOG2 (BAR_LOG2)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (addr_strobe),
    .ad_hi     (ad_in[31:BAR_LOG2]),
    .ad_lo     (ad_in[1:0]),
    .cmd       (cbe_n),
    .idsel     (idsel),
    .mem_en    (mem_en),
    .bar_base  (bar_base),
    .cfg_sel_q (dec_cfg),
    .mem_sel_q (dec_mem),
    .rd_q      (dec_rd),
    .disc_q    (dec_disc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= 1'b1;
      addr_q  <= '0;
      cfg_q   <= 1'b0;
      rd_q    <= 1'b0;
      disc_q  <= 1'b0;
    end else begin
      frame_q <= frame_n;
      unique case (state_q)
        ST_IDLE: begin
          if (addr_strobe) begin
            addr_q  <= ad_in[KEEP-1:2];
            state_q <= ST_DEC;
          end
        end
        ST_DEC: begin
          if (dec_cfg || dec_mem) begin
            cfg_q   <= dec_cfg;
            rd_q    <= dec_rd;
            disc_q  <= dec_mem && dec_disc;
            state_q <= ST_DATA;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_DATA: begin
          if (!irdy_n) begin
            addr_q <= addr_q + 1'b1;
            if (disc_q) begin
              state_q <= frame_n ? ST_TURN : ST_DISC;
            end else if (frame_n) begin
              state_q <= ST_TURN;
            end
          end
        end
        ST_DISC: begin
          if (frame_n) begin
            state_q <= ST_TURN;
          end
        end
        ST_TURN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign devsel_n   = !((state_q == ST_DATA) || (state_q == ST_DISC));
  assign trdy_n     = !(state_q == ST_DATA);
  assign stop_n     = !(((state_q == ST_DATA) && disc_q) || (state_q == ST_DISC));
  assign ctl_oe     = (state_q == ST_DATA) || (state_q == ST_DISC) || (state_q == ST_TURN);
  assign ad_oe      = (state_q == ST_DATA) && rd_q;
  assign ad_out     = cfg_q ? cfg_rdata : mem_rdata;
  assign hit        = dec_mem;
  assign mem_addr   = addr_q[BAR_LOG2-1:2];
  assign mem_wvalid = xfer && !cfg_q && !rd_q;
  assign mem_wdata  = ad_in;
  assign mem_be     = ~cbe_n;

endmodule

// File: rtl/pci_cfg_target_chk.sv
module pci_cfg_target_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_n,
  input logic irdy_n,
  input logic devsel_n,
  input logic trdy_n,
  input logic stop_n,
  input logic ctl_oe,
  input logic ad_oe,
  input logic hit,
  input logic mem_wvalid,
  input logic addr_strobe
);

  a_r2_medium_select: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(addr_strobe, 2));

  a_r2_trdy_with_select: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  a_r8_hit_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(addr_strobe));

  a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !trdy_n && !irdy_n && !frame_n) |=> (trdy_n && !stop_n && !devsel_n));

  a_r11_beat_in_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> (!trdy_n && !irdy_n));

  a_r11_drive_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !devsel_n);

  a_r12_release_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_n) |=> !ctl_oe);

endmodule

bind pci_cfg_target pci_cfg_target_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_n     (frame_n),
  .irdy_n      (irdy_n),
  .devsel_n    (devsel_n),
  .trdy_n      (trdy_n),
  .stop_n      (stop_n),
  .ctl_oe      (ctl_oe),
  .ad_oe       (ad_oe),
  .hit         (hit),
  .mem_wvalid  (mem_wvalid),
  .addr_strobe (addr_strobe)
);

// File: tb/pci_cfg_target_bench.sv
module pci_cfg_target_bench;

  localparam logic [3:0] MR = 4'b0110;
  localparam logic [3:0] MW = 4'b0111;
  localparam logic [3:0] CR = 4'b1010;
  localparam logic [3:0] CW = 4'b1011;

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic        idsel;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic        claim;
    logic        stop;
    logic        hitx;
    logic        chk;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  CR, 32'h0000_0000, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0F31_ABCD}, // R3
    '{4'd3,  CR, 32'h0000_0008, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0580_0002}, // R3
    '{4'd4,  CR, 32'h0000_000C, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_0000}, // R4
    '{4'd4,  CR, 32'h0000_003C, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_0000}, // R4
    '{4'd13, CR, 32'h0000_0004, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0200_0000}, // R13
    '{4'd13, CR, 32'h0000_0010, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_0000}, // R13
    '{4'd6,  CW, 32'h0000_0010, 1'b1, 4'hF, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0}, // R6
    '{4'd6,  CR, 32'h0000_0010, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'hFFFF_F000}, // R6
    '{4'd6,  CW, 32'h0000_0010, 1'b1, 4'hF, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0}, // R6
    '{4'd6,  CR, 32'h0000_0010, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h8000_0000}, // R6
    '{4'd8,  MR, 32'h8000_0010, 1'b0, 4'hF, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R8 disabled
    '{4'd5,  CW, 32'h0000_0004, 1'b1, 4'h1, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0}, // R5
    '{4'd5,  CR, 32'h0000_0004, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0200_0002}, // R5
    '{4'd8,  MR, 32'h8000_0010, 1'b0, 4'hF, 32'h0, 1'b1, 1'b0, 1'b1, 1'b1, 32'hC0DE_0004}, // R8
    '{4'd8,  MR, 32'h9000_0010, 1'b0, 4'hF, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R8 miss
    '{4'd1,  CR, 32'h0000_0000, 1'b0, 4'hF, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R1 no IDSEL
    '{4'd1,  CR, 32'h0000_0001, 1'b1, 4'hF, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R1 AD[1:0]
    '{4'd4,  CW, 32'h0000_000C, 1'b1, 4'hF, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0}, // R4
    '{4'd4,  CR, 32'h0000_000C, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_0000}, // R4
    '{4'd7,  CW, 32'h0000_0004, 1'b1, 4'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},         // R7
    '{4'd7,  CR, 32'h0000_0004, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0200_0002}, // R7
    '{4'd7,  CW, 32'h0000_0010, 1'b1, 4'h1, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0}, // R7
    '{4'd7,  CR, 32'h0000_0010, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h8000_0000}, // R7
    '{4'd10, MR, 32'h8000_0012, 1'b0, 4'hF, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, 32'hC0DE_0004}, // R10 wrap
    '{4'd10, MR, 32'h8000_0011, 1'b0, 4'hF, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, 32'hC0DE_0004}, // R10 other
    '{4'd1,  CR, 32'h0000_007C, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_0000}  // R1 empty
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic        idsel = 1'b0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, trdy_n, stop_n, ctl_oe, hit;
  logic [9:0]  mem_addr;
  logic        mem_wvalid;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata;

  always #10 clk = ~clk;

  assign mem_rdata = 32'hC0DE_0000 | {22'b0, mem_addr};

  pci_cfg_target u_pci_cfg_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe),
    .hit(hit), .mem_addr(mem_addr), .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int cyc = 0;

  int          wcnt = 0;
  logic [9:0]  wl_addr [16];
  logic [31:0] wl_data [16];
  logic [3:0]  wl_be   [16];

  always @(negedge clk) begin
    if (mem_wvalid && wcnt < 16) begin
      wl_addr[wcnt] = mem_addr;
      wl_data[wcnt] = mem_wdata;
      wl_be[wcnt]   = mem_be;
      wcnt = wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic f, input logic i, input logic s, input logic [3:0] c, input logic [31:0] a);
    @(posedge clk);
    #1;
    frame_n = f; irdy_n = i; idsel = s; cbe_n = c; ad_in = a;
  endtask

  task automatic run_vec(input vec_t v, input int n);
    string tag;
    tag = $sformatf("R%0d vec%0d", v.req, n);
    drive(1'b0, 1'b1, v.idsel, v.cmd, v.addr);
    drive(1'b1, 1'b0, 1'b0, ~v.be, v.wdata);
    @(negedge clk);
    chk(hit == v.hitx, {tag, " hit"}, {31'b0, hit}, {31'b0, v.hitx});
    chk(devsel_n == 1'b1, {tag, " R2 devsel early"}, {31'b0, devsel_n}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk(devsel_n == !v.claim, {tag, " R2 devsel"}, {31'b0, devsel_n}, {31'b0, !v.claim});
    chk(trdy_n == !v.claim, {tag, " R2 trdy"}, {31'b0, trdy_n}, {31'b0, !v.claim});
    chk(stop_n == !v.stop, {tag, " stop"}, {31'b0, stop_n}, {31'b0, !v.stop});
    chk(ad_oe == (v.claim && !v.cmd[0]), {tag, " R11 ad_oe"}, {31'b0, ad_oe}, {31'b0, v.claim && !v.cmd[0]});
    if (v.chk) chk(ad_out == v.rdata, {tag, " data"}, ad_out, v.rdata);
    drive(1'b1, 1'b1, 1'b0, 4'hF, 32'h0);
    @(negedge clk);
    chk(devsel_n == 1'b1 && ctl_oe == v.claim, {tag, " R12 release"}, {30'b0, ctl_oe, devsel_n}, {30'b0, v.claim, 1'b1});
    drive(1'b1, 1'b1, 1'b0, 4'hF, 32'h0);
    @(negedge clk);
    chk(ctl_oe == 1'b0, {tag, " R12 idle"}, {31'b0, ctl_oe}, 32'd0);
  endtask

  initial begin
    int w0;
    #35;
    @(negedge clk);
    // R13: reset state of the bus outputs
    chk({devsel_n, trdy_n, stop_n, ctl_oe, ad_oe} == 5'b11100, "R13 reset outputs",
        {27'b0, devsel_n, trdy_n, stop_n, ctl_oe, ad_oe}, 32'h1C);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R9 R11: linear write burst of three dwords starting at offset 8
    w0 = wcnt;
    drive(1'b0, 1'b1, 1'b0, MW, 32'h8000_0020);
    drive(1'b0, 1'b0, 1'b0, 4'h0, 32'hD000_0000);
    drive(1'b0, 1'b0, 1'b0, 4'h0, 32'hD000_0000);
    @(negedge clk);
    chk(trdy_n == 1'b0 && stop_n == 1'b1, "R9 first phase", {30'b0, trdy_n, stop_n}, 32'd1);
    drive(1'b0, 1'b0, 1'b0, 4'hC, 32'hD000_0001);
    @(negedge clk);
    chk(trdy_n == 1'b0 && stop_n == 1'b1, "R9 second phase", {30'b0, trdy_n, stop_n}, 32'd1);
    drive(1'b1, 1'b0, 1'b0, 4'h0, 32'hD000_0002);
    drive(1'b1, 1'b1, 1'b0, 4'hF, 32'h0);
    @(negedge clk);
    chk(devsel_n == 1'b1 && ctl_oe == 1'b1, "R12 burst release", {30'b0, devsel_n, ctl_oe}, 32'd3);
    drive(1'b1, 1'b1, 1'b0, 4'hF, 32'h0);
    chk(wcnt - w0 == 3, "R9 beat count", wcnt - w0, 32'd3);
    for (int k = 0; k < 3; k++) begin
      chk(wl_addr[w0+k] == 10'(8 + k), "R9 offset", {22'b0, wl_addr[w0+k]}, 32'(8 + k));
      chk(wl_data[w0+k] == 32'hD000_0000 + k, "R11 wdata", wl_data[w0+k], 32'hD000_0000 + k);
    end
    chk(wl_be[w0+1] == 4'h3, "R11 byte enables", {28'b0, wl_be[w0+1]}, 32'h3);

    // R10: wrap-ordered write burst is cut after one dword
    w0 = wcnt;
    drive(1'b0, 1'b1, 1'b0, MW, 32'h8000_0042);
    drive(1'b0, 1'b0, 1'b0, 4'h0, 32'hE000_0000);
    drive(1'b0, 1'b0, 1'b0, 4'h0, 32'hE000_0000);
    @(negedge clk);
    chk(trdy_n == 1'b0 && stop_n == 1'b0, "R10 disconnect with data", {30'b0, trdy_n, stop_n}, 32'd0);
    drive(1'b1, 1'b0, 1'b0, 4'h0, 32'hE000_0001);
    @(negedge clk);
    chk({trdy_n, stop_n, devsel_n} == 3'b100, "R10 stop held", {29'b0, trdy_n, stop_n, devsel_n}, 32'h4);
    drive(1'b1, 1'b1, 1'b0, 4'hF, 32'h0);
    @(negedge clk);
    chk({stop_n, devsel_n, ctl_oe} == 3'b111, "R12 disconnect release", {29'b0, stop_n, devsel_n, ctl_oe}, 32'h7);
    drive(1'b1, 1'b1, 1'b0, 4'hF, 32'h0);
    @(negedge clk);
    chk(wcnt - w0 == 1, "R10 single beat", wcnt - w0, 32'd1);
    chk(wl_addr[w0] == 10'h10 && wl_data[w0] == 32'hE000_0000, "R10 beat content",
        wl_data[w0], 32'hE000_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog got=%0d exp=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule